// File: doc/BRIEF.md
# Boundary-Scan Register Chain

This block is a row of boundary-scan cells between a device core and its I/O pins. Each pin has three cells: one for the value coming in from the pad, one for the value the core drives out, and one for the output enable. Every cell has a capture flop and an update flop. A TAP state decoder outside this block supplies one-cycle capture, shift and update strobes and a mode bit. The mode bit selects non-intrusive sampling or external test.

In sampling mode the core keeps full control of the pins. The chain can still snapshot the live signals, shift them out on TDO, and preload new values into the update flops. In external-test mode the update flops take over the pins. They drive the output values and enables, and they also feed the values the core sees from the pins. This lets known levels be forced onto board nets so that opens and shorts can be found.

A global device output-enable gate can tristate every pin. Even when it does, each enable cell still captures the enable value the core is asking for.

Top module: `bscan_chain`

## Requirements
- R1: On a rising `tck` with `capture_en` high, every capture flop loads its live signal. Chain bit 3p loads `pin_in[p]`, bit 3p+1 loads `core_out[p]`, and bit 3p+2 loads `core_oe[p]`.
- R2: On a rising `tck` with `shift_en` high, the chain moves one position toward TDO. Bit 0 loads `tdi` and bit k loads bit k-1. The chain has 3·N_PINS bits.
- R3: `tdo` shows the last chain bit (index 3·N_PINS-1) and changes only on the falling edge of `tck`. After a capture, the first 3·N_PINS bits on `tdo` are the captured values from the highest index down to bit 0.
- R4: On a rising `tck` with `update_en` high, each update flop copies its capture flop. Without that strobe the update flops keep their value, including while the chain shifts.
- R5: When no strobe is high, the capture flops keep their value whatever the live signals do.
- R6: With `extest` low, `pin_out` equals `core_out`, `pin_oe` equals `core_oe` (subject to R8), and `core_in` equals `pin_in`.
- R7: With `extest` high, `pin_out[p]`, `pin_oe[p]` and `core_in[p]` come from the update flops of chain bits 3p+1, 3p+2 and 3p.
- R8: With `dev_oe_feature` high and `dev_oe` low, every `pin_oe` bit is 0 in both modes. The enable cells still capture `core_oe`. With `dev_oe_feature` low, `dev_oe` has no effect.
- R9: A synchronous `rst`, sampled on the rising edge of `tck`, clears all capture and update flops. `tdo` is cleared on the next falling edge.

Ports are listed in the order of the top module's port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high test reset |
| capture_en | input | 1 | Capture strobe from the TAP decoder |
| shift_en | input | 1 | Shift strobe from the TAP decoder |
| update_en | input | 1 | Update strobe from the TAP decoder |
| extest | input | 1 | 1 = external test, 0 = sample/preload |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, retimed on the falling edge |
| core_out | input | N_PINS | Output values from the core |
| core_oe | input | N_PINS | Output enables from the core |
| core_in | output | N_PINS | Pin values as seen by the core |
| pin_in | input | N_PINS | Values arriving from the pads |
| pin_out | output | N_PINS | Values driven to the pads |
| pin_oe | output | N_PINS | Pad output enables |
| dev_oe_feature | input | 1 | Turns on the global output-enable gate |
| dev_oe | input | 1 | Device output enable; low tristates all pins when the gate is on |

## Verification
A capture flop that takes the wrong source, or sits at the wrong chain position, shows up as a misplaced bit in the serial stream. That error is visible within 3·N_PINS shift cycles after a capture. A wrong or leaking update flop shows up on `pin_out`, `pin_oe` or `core_in` in the same cycle that external-test mode is selected. A mux that lets update data through during sampling shows up on those same ports as soon as the update flops differ from the core values. The bench loads preload patterns that differ from the live core data, so that every such mistake reaches a port.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    localparam int CELLS_PER_PIN = 3;

    typedef enum logic [1:0] {
        CELL_IN  = 2'd0,
        CELL_OUT = 2'd1,
        CELL_OE  = 2'd2
    } cell_kind_e;

    typedef struct packed {
        logic capture;
        logic shift;
        logic update;
    } strobe_t;

    function automatic int chain_pos(input int pin, input cell_kind_e kind);
        return CELLS_PER_PIN * pin + int'(kind);
    endfunction

endpackage

// File: rtl/bscan_cell.sv
module bscan_cell
    import bscan_pkg::*;
(
    input  logic    tck,
    input  logic    rst,
    input  strobe_t stb,
    input  logic    par_in,
    input  logic    ser_in,
    output logic    cap_q,
    output logic    upd_q
);

    always_ff @(posedge tck) begin
        if (rst) begin
            cap_q <= 1'b0;
        end else if (stb.capture) begin
            cap_q <= par_in;
        end else if (stb.shift) begin
            cap_q <= ser_in;
        end
    end

    always_ff @(posedge tck) begin
        if (rst) begin
            upd_q <= 1'b0;
        end else if (stb.update) begin
            upd_q <= cap_q;
        end
    end

    // R1
    capture_load_chk: assert property (@(posedge tck) disable iff (rst)
        stb.capture |=> cap_q == $past(par_in));

    // R2
    shift_move_chk: assert property (@(posedge tck) disable iff (rst)
        (stb.shift && !stb.capture) |=> cap_q == $past(ser_in));

    // R5
    capture_hold_chk: assert property (@(posedge tck) disable iff (rst)
        (!stb.shift && !stb.capture) |=> $stable(cap_q));

    // R4
    update_copy_chk: assert property (@(posedge tck) disable iff (rst)
        stb.update |=> upd_q == $past(cap_q));

    // R4
    update_hold_chk: assert property (@(posedge tck) disable iff (rst)
        !stb.update |=> $stable(upd_q));

    // R9
    reset_clear_chk: assert property (@(posedge tck)
        rst |=> (cap_q == 1'b0 && upd_q == 1'b0));

endmodule

// File: rtl/bscan_tdo_stage.sv
module bscan_tdo_stage (
    input  logic tck,
    input  logic rst,
    input  logic last_bit,
    output logic tdo
);

    always_ff @(negedge tck) begin
        if (rst) begin
            tdo <= 1'b0;
        end else begin
            tdo <= last_bit;
        end
    end

endmodule

// File: rtl/bscan_pin_mux.sv
module bscan_pin_mux #(
    parameter int N_PINS = 4
) (
    input  logic              extest,
    input  logic              dev_oe_feature,
    input  logic              dev_oe,
    input  logic [N_PINS-1:0] core_out,
    input  logic [N_PINS-1:0] core_oe,
    input  logic [N_PINS-1:0] pin_in,
    input  logic [N_PINS-1:0] upd_in,
    input  logic [N_PINS-1:0] upd_out,
    input  logic [N_PINS-1:0] upd_oe,
    output logic [N_PINS-1:0] core_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe
);

    logic gate_off;
    assign gate_off = dev_oe_feature && !dev_oe;

    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        logic oe_sel;
        always_comb begin
            if (extest) begin
                pin_out[p] = upd_out[p];
                oe_sel     = upd_oe[p];
                core_in[p] = upd_in[p];
            end else begin
                pin_out[p] = core_out[p];
                oe_sel     = core_oe[p];
                core_in[p] = pin_in[p];
            end
            pin_oe[p] = oe_sel && !gate_off;
        end
    end

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
    import bscan_pkg::*;
#(
    parameter int N_PINS = 4
) (
    input  logic              tck,
    input  logic              rst,
    input  logic              capture_en,
    input  logic              shift_en,
    input  logic              update_en,
    input  logic              extest,
    input  logic              tdi,
    output logic              tdo,
    input  logic [N_PINS-1:0] core_out,
    input  logic [N_PINS-1:0] core_oe,
    output logic [N_PINS-1:0] core_in,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe,
    input  logic              dev_oe_feature,
    input  logic              dev_oe
);

    localparam int LEN = CELLS_PER_PIN * N_PINS;

    strobe_t          stb;
    logic [LEN-1:0]   par;
    logic [LEN-1:0]   ser;
    logic [LEN-1:0]   cap;
    logic [LEN-1:0]   upd;
    logic [N_PINS-1:0] upd_in, upd_out, upd_oe;

    assign stb = '{capture: capture_en, shift: shift_en, update: update_en};

    for (genvar p = 0; p < N_PINS; p++) begin : g_pin_map
        localparam int BI = chain_pos(p, CELL_IN);
        localparam int BO = chain_pos(p, CELL_OUT);
        localparam int BE = chain_pos(p, CELL_OE);
        assign par[BI]    = pin_in[p];
        assign par[BO]    = core_out[p];
        assign par[BE]    = core_oe[p];
        assign upd_in[p]  = upd[BI];
        assign upd_out[p] = upd[BO];
        assign upd_oe[p]  = upd[BE];
    end

    for (genvar k = 0; k < LEN; k++) begin : g_cell
        if (k == 0) begin : g_head
            assign ser[k] = tdi;
        end else begin : g_link
            assign ser[k] = cap[k-1];
        end

        bscan_cell u_cell (
            .tck    (tck),
            .rst    (rst),
            .stb    (stb),
            .par_in (par[k]),
            .ser_in (ser[k]),
            .cap_q  (cap[k]),
            .upd_q  (upd[k])
        );
    end

    bscan_tdo_stage u_tdo (
        .tck      (tck),
        .rst      (rst),
        .last_bit (cap[LEN-1]),
        .tdo      (tdo)
    );

    bscan_pin_mux #(.N_PINS(N_PINS)) u_mux (
        .extest         (extest),
        .dev_oe_feature (dev_oe_feature),
        .dev_oe         (dev_oe),
        .core_out       (core_out),
        .core_oe        (core_oe),
        .pin_in         (pin_in),
        .upd_in         (upd_in),
        .upd_out        (upd_out),
        .upd_oe         (upd_oe),
        .core_in        (core_in),
        .pin_out        (pin_out),
        .pin_oe         (pin_oe)
    );

    // R8
    global_oe_off_chk: assert property (@(posedge tck) disable iff (rst)
        (dev_oe_feature && !dev_oe) |-> pin_oe == '0);

    // R6
    sample_passthru_chk: assert property (@(posedge tck) disable iff (rst)
        (!extest && !dev_oe_feature) |-> (pin_out == core_out && pin_oe == core_oe));

endmodule

// File: tb/bscan_chain_bench.sv
`timescale 1ns/1ps
module bscan_chain_bench;

    localparam int N   = 4;
    localparam int LEN = 3 * N;

    typedef struct packed {
        logic [N-1:0]   pin_in;
        logic [N-1:0]   core_out;
        logic [N-1:0]   core_oe;
        logic [LEN-1:0] load;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{4'hA, 4'h5, 4'hF, 12'hA5C},
        '{4'h3, 4'hC, 4'h0, 12'h3F0},
        '{4'hF, 4'h0, 4'h9, 12'hFFF},
        '{4'h0, 4'hF, 4'h6, 12'h000}
    };

    logic tck = 1'b0;
    logic rst, capture_en, shift_en, update_en, extest, tdi, tdo;
    logic [N-1:0] core_out, core_oe, core_in, pin_in, pin_out, pin_oe;
    logic dev_oe_feature, dev_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 tck = ~tck;

    bscan_chain #(.N_PINS(N)) u_bscan_chain (
        .tck(tck), .rst(rst), .capture_en(capture_en), .shift_en(shift_en),
        .update_en(update_en), .extest(extest), .tdi(tdi), .tdo(tdo),
        .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .dev_oe_feature(dev_oe_feature), .dev_oe(dev_oe)
    );

    task automatic tick();
        @(negedge tck);
        #2;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [LEN-1:0] cap_of(input logic [N-1:0] pi,
                                              input logic [N-1:0] co,
                                              input logic [N-1:0] oe);
        logic [LEN-1:0] r;
        for (int p = 0; p < N; p++) begin
            r[3*p]   = pi[p];
            r[3*p+1] = co[p];
            r[3*p+2] = oe[p];
        end
        return r;
    endfunction

    function automatic logic [N-1:0] field(input logic [LEN-1:0] v, input int off);
        logic [N-1:0] r;
        for (int p = 0; p < N; p++) r[p] = v[3*p+off];
        return r;
    endfunction

    task automatic do_capture();
        capture_en = 1'b1;
        tick();
        capture_en = 1'b0;
    endtask

    // shifts LEN bits: returns the bits seen on tdo (index LEN-1 first), loads 'load'
    task automatic do_shift(input logic [LEN-1:0] load, output logic [LEN-1:0] seen);
        shift_en = 1'b1;
        for (int i = 0; i < LEN; i++) begin
            seen[LEN-1-i] = tdo;
            tdi = load[LEN-1-i];
            tick();
        end
        shift_en = 1'b0;
        tdi = 1'b0;
    endtask

    task automatic do_update();
        update_en = 1'b1;
        tick();
        update_en = 1'b0;
    endtask

    initial begin
        logic [LEN-1:0] seen;
        rst = 1'b1; capture_en = 0; shift_en = 0; update_en = 0; extest = 1'b1; tdi = 0;
        core_out = '1; core_oe = '1; pin_in = '1; dev_oe_feature = 0; dev_oe = 1'b1;
        tick(); tick(); tick();
        rst = 1'b0;
        tick();

        // R9 reset state visible through external-test mode and tdo
        check("R9 pin_out", pin_out, 0);
        check("R9 pin_oe",  pin_oe, 0);
        check("R9 core_in", core_in, 0);
        check("R9 tdo", tdo, 0);
        do_shift('0, seen);
        check("R9 chain", seen, 0);
        extest = 1'b0;

        // table walk
        for (int v = 0; v < 4; v++) begin
            logic [LEN-1:0] exp_cap;
            pin_in = VECS[v].pin_in; core_out = VECS[v].core_out; core_oe = VECS[v].core_oe;
            extest = 1'b0;
            tick();
            check("R6 pin_out", pin_out, core_out);
            check("R6 pin_oe", pin_oe, core_oe);
            check("R6 core_in", core_in, pin_in);
            exp_cap = cap_of(pin_in, core_out, core_oe);
            do_capture();
            do_shift(VECS[v].load, seen);
            check("R1 R3 captured stream", seen, exp_cap);
            do_update();
            check("R6 pin_out after preload", pin_out, core_out);
            check("R6 pin_oe after preload", pin_oe, core_oe);
            extest = 1'b1;
            #1;
            check("R7 pin_out", pin_out, field(VECS[v].load, 1));
            check("R7 pin_oe", pin_oe, field(VECS[v].load, 2));
            check("R7 core_in", core_in, field(VECS[v].load, 0));
            extest = 1'b0;
        end

        // R2: bits entered at tdi return after a full pass
        do_shift(12'h6B3, seen);
        do_shift(12'h000, seen);
        check("R2 pass-through", seen, 12'h6B3);

        // R4: update flops hold while shifting, copy on strobe
        extest = 1'b1;
        do_shift(12'h924, seen);
        do_update();
        check("R4 load A", pin_out, field(12'h924, 1));
        do_shift(12'h249, seen);
        check("R4 hold during shift out", pin_out, field(12'h924, 1));
        check("R4 hold during shift oe", pin_oe, field(12'h924, 2));
        do_update();
        check("R4 load B out", pin_out, field(12'h249, 1));
        check("R4 load B in", core_in, field(12'h249, 0));
        extest = 1'b0;

        // R5: capture flops hold with no strobe while inputs change
        pin_in = 4'h5; core_out = 4'h3; core_oe = 4'hC;
        do_capture();
        pin_in = 4'hA; core_out = 4'hC; core_oe = 4'h3;
        tick(); tick(); tick();
        do_shift('0, seen);
        check("R5 hold", seen, cap_of(4'h5, 4'h3, 4'hC));

        // R8: global gate tristates but enable cells capture core_oe
        dev_oe_feature = 1'b1; dev_oe = 1'b0; core_oe = 4'hF;
        tick();
        check("R8 sample gated", pin_oe, 0);
        do_capture();
        do_shift(12'hFFF, seen);
        check("R8 oe cells capture", field(seen, 2), 4'hF);
        do_update();
        extest = 1'b1;
        #1;
        check("R8 extest gated", pin_oe, 0);
        dev_oe = 1'b1;
        #1;
        check("R8 gate released", pin_oe, 4'hF);
        dev_oe_feature = 1'b0; dev_oe = 1'b0; extest = 1'b0;
        #1;
        check("R8 feature off ignores dev_oe", pin_oe, core_oe);

        // R3: tdo changes only on falling edge
        do_shift(12'h800, seen);
        shift_en = 1'b1; tdi = 1'b0;
        @(posedge tck); #1;
        check("R3 tdo stable after rise", tdo, 1);
        @(negedge tck); #1;
        check("R3 tdo moves on fall", tdo, 0);
        shift_en = 1'b0;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule